// File: doc/BRIEF.md
# Latched-Result Arithmetic Logic Unit

This block is the arithmetic and logic stage of a small accumulator-style datapath. It takes two 8-bit operands and a 4-bit operation code. The upper three bits of the code pick a functional unit: arithmetic, shift, AND, OR or XOR. The lowest bit modifies the chosen unit. It turns add into subtract and a right shift into a left shift. Every unit evaluates its operands all the time, and the code only chooses which answer is kept.

On a rising clock edge with the compute strobe high, the chosen answer is stored in an internal result register. Zero and carry flags are stored with it. At any later time the output-enable drives the stored value onto a shared data bus, whatever the operands hold by then. The bus does not use a tri-state: a separate drive-valid line tells the bus owner whether the block is driving.

Top module: `alu_latched`

## Requirements
- R1: Code 0000 stores (A + B) mod 256. The carry flag takes the carry out of bit 7.
- R2: Code 0001 stores (A - B) mod 256. The carry flag is set exactly when A < B unsigned, which is a borrow.
- R3: Code 0010 stores A shifted right by one with a zero filled into bit 7. Code 0011 stores A shifted left by one with a zero filled into bit 0. The carry flag is cleared for both.
- R4: Code 0100 stores A AND B, code 0110 stores A OR B and code 1000 stores A XOR B. The carry flag is cleared for all three.
- R5: Every other code stores zero: 0101, 0111, 1001 and 1010 to 1111. The carry flag is cleared and the zero flag is set.
- R6: The result and both flags change only on a clock edge with compute_en high. With compute_en low they hold, whatever the operands and the code do.
- R7: With out_en high, bus_data equals the stored result and bus_valid is 1. With out_en low, bus_valid is 0 and bus_data is 0.
- R8: After each capture, zero_flag is 1 exactly when the stored result is zero.
- R9: A synchronous active-high reset clears the result, zero_flag and carry_flag, and it takes priority over compute_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | 8 | First operand (A) |
| opnd_b | input | 8 | Second operand (B) |
| op_code | input | 4 | Operation code: bits 3..1 select the unit, bit 0 modifies it |
| compute_en | input | 1 | Capture the selected result and flags on this edge |
| out_en | input | 1 | Drive the stored result onto the bus |
| bus_data | output | 8 | Stored result while out_en is high, otherwise zero |
| bus_valid | output | 1 | High while the block drives the bus |
| zero_flag | output | 1 | Last captured result was zero |
| carry_flag | output | 1 | Carry or borrow out of bit 7 from the last add or subtract |

## Verification
On every cycle the assertions check four things:
- The value and carry captured for add and subtract, against the operands sampled at the strobe.
- That the carry is clear after any other code.
- That the result and flags hold while the strobe is low, and that reset clears them.
- That the zero flag matches the result and the bus follows the output-enable.

Only the bench's scenarios can show the rest:
- The shift fill directions and the logic operations.
- That every undefined code stores zero.
- That a strobe coinciding with reset is overridden.
- That the bus value stays stable while the operands change.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned UNIT_W = OP_W - 1;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_ARITH = 3'd0,
        UNIT_SHIFT = 3'd1,
        UNIT_AND   = 3'd2,
        UNIT_OR    = 3'd3,
        UNIT_XOR   = 3'd4
    } unit_e;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic              modf;
        logic              legal;
    } opdec_t;

    function automatic opdec_t decode_op(input logic [OP_W-1:0] op);
        opdec_t d;
        d.unit = op[OP_W-1:1];
        d.modf = op[0];
        case (op[OP_W-1:1])
            UNIT_ARITH, UNIT_SHIFT:     d.legal = 1'b1;
            UNIT_AND, UNIT_OR, UNIT_XOR: d.legal = ~op[0];
            default:                    d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] sum;
    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign res   = sum[W-1:0];
    // for subtraction a clear carry out of the adder means a borrow
    assign cout  = sub ? ~sum[W] : sum[W];
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic         left,
    output logic [W-1:0] res
);
    always_comb begin
        if (left) res = {a[W-2:0], 1'b0};
        else      res = {1'b0, a[W-1:1]};
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_r,
    output logic [W-1:0] or_r,
    output logic [W-1:0] xor_r
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_r[i] = a[i] & b[i];
        assign or_r[i]  = a[i] | b[i];
        assign xor_r[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/alu_latched.sv
module alu_latched
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = alu_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [OP_W-1:0]   op_code,
    input  logic              compute_en,
    input  logic              out_en,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_valid,
    output logic              zero_flag,
    output logic              carry_flag
);
    opdec_t dec;
    assign dec = decode_op(op_code);

    logic [DATA_W-1:0] arith_r, shift_r, and_r, or_r, xor_r;
    logic              arith_c;

    alu_arith #(.W(DATA_W)) u_arith (
        .a(opnd_a), .b(opnd_b), .sub(dec.modf), .res(arith_r), .cout(arith_c)
    );

    alu_shift #(.W(DATA_W)) u_shift (
        .a(opnd_a), .left(dec.modf), .res(shift_r)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .a(opnd_a), .b(opnd_b), .and_r(and_r), .or_r(or_r), .xor_r(xor_r)
    );

    logic [DATA_W-1:0] nxt_res;
    logic              nxt_carry;

    always_comb begin
        nxt_res   = '0;
        nxt_carry = 1'b0;
        if (dec.legal) begin
            case (dec.unit)
                UNIT_ARITH: begin
                    nxt_res   = arith_r;
                    nxt_carry = arith_c;
                end
                UNIT_SHIFT: nxt_res = shift_r;
                UNIT_AND:   nxt_res = and_r;
                UNIT_OR:    nxt_res = or_r;
                UNIT_XOR:   nxt_res = xor_r;
                default:    nxt_res = '0;
            endcase
        end
    end

    logic [DATA_W-1:0] res_q;
    logic              zf_q, cf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            zf_q  <= 1'b0;
            cf_q  <= 1'b0;
        end else if (compute_en) begin
            res_q <= nxt_res;
            zf_q  <= (nxt_res == '0);
            cf_q  <= nxt_carry;
        end
    end

    assign zero_flag  = zf_q;
    assign carry_flag = cf_q;
    assign bus_valid  = out_en;
    assign bus_data   = out_en ? res_q : '0;
endmodule

// File: rtl/alu_latched_chk.sv
module alu_latched_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   op_code,
    input logic         compute_en,
    input logic         out_en,
    input logic [W-1:0] res_q,
    input logic [W-1:0] bus_data,
    input logic         bus_valid,
    input logic         zero_flag,
    input logic         carry_flag
);
    p_add_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(compute_en) && !$past(rst) && $past(op_code) == 4'b0000)
        |-> ({carry_flag, res_q} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    p_sub_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(compute_en) && !$past(rst) && $past(op_code) == 4'b0001)
        |-> (res_q == W'($past(opnd_a) - $past(opnd_b))
             && carry_flag == ($past(opnd_a) < $past(opnd_b))));

    p_carry_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(compute_en) && !$past(rst) && $past(op_code[3:1]) != 3'b000)
        |-> !carry_flag);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !compute_en |=> ($stable(res_q) && $stable(zero_flag) && $stable(carry_flag)));

    p_bus_on_r7: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (bus_valid && bus_data == res_q));

    p_bus_off_r7: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (!bus_valid && bus_data == '0));

    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(compute_en) && !$past(rst)) |-> (zero_flag == (res_q == '0)));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !zero_flag && !carry_flag));
endmodule

bind alu_latched alu_latched_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
    .compute_en(compute_en), .out_en(out_en), .res_q(res_q), .bus_data(bus_data),
    .bus_valid(bus_valid), .zero_flag(zero_flag), .carry_flag(carry_flag)
);

// File: tb/alu_latched_tb.sv
`timescale 1ns/1ps
module alu_latched_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [3:0] op_code = '0;
    logic       compute_en = 1'b0, out_en = 1'b1;
    logic [7:0] bus_data;
    logic       bus_valid, zero_flag, carry_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_latched u_dut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
        .compute_en(compute_en), .out_en(out_en), .bus_data(bus_data),
        .bus_valid(bus_valid), .zero_flag(zero_flag), .carry_flag(carry_flag)
    );

    function automatic logic [8:0] ref_alu(input logic [3:0] op, input logic [7:0] a,
                                           input logic [7:0] b);
        case (op)
            4'b0000: return {1'b0, a} + {1'b0, b};
            4'b0001: return {(a < b), 8'(a - b)};
            4'b0010: return {1'b0, 1'b0, a[7:1]};
            4'b0011: return {1'b0, a[6:0], 1'b0};
            4'b0100: return {1'b0, a & b};
            4'b0110: return {1'b0, a | b};
            4'b1000: return {1'b0, a ^ b};
            default: return 9'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010, 4'b0011: return "R3";
            4'b0100, 4'b0110, 4'b1000: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, capture on the next rising edge, sample at the following falling edge
    task automatic capture(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; compute_en = 1'b1;
        @(negedge clk);
        compute_en = 1'b0;
    endtask

    task automatic verify(input string req, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b);
        logic [8:0] e;
        e = ref_alu(op, a, b);
        chk(req, "result", int'(bus_data), int'(e[7:0]));
        chk(req, "carry", int'(carry_flag), int'(e[8]));
        chk("R8", "zero", int'(zero_flag), int'(e[7:0] == 8'd0));
    endtask

    task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        capture(op, a, b);
        verify(req_of(op), op, a, b);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset result", int'(bus_data), 0);
        chk("R9", "reset zero", int'(zero_flag), 0);
        chk("R9", "reset carry", int'(carry_flag), 0);
        rst = 1'b0;

        // R1 corners
        run_op(4'b0000, 8'd255, 8'd1);
        run_op(4'b0000, 8'd100, 8'd27);
        run_op(4'b0000, 8'd200, 8'd200);
        // R2 corners
        run_op(4'b0001, 8'd5, 8'd5);
        run_op(4'b0001, 8'd3, 8'd4);
        run_op(4'b0001, 8'd0, 8'd255);
        // R3 fill directions
        run_op(4'b0010, 8'h81, 8'h00);
        run_op(4'b0011, 8'h81, 8'h00);
        run_op(4'b0010, 8'h01, 8'hFF);
        // R4 after an arithmetic carry, so the carry must clear
        run_op(4'b0000, 8'hF0, 8'h20);
        run_op(4'b0100, 8'hF0, 8'h3C);
        run_op(4'b0110, 8'hF0, 8'h0C);
        run_op(4'b1000, 8'hFF, 8'h0F);
        // R5: every undefined code stores zero
        for (int k = 0; k < 16; k++) begin
            if (k inside {0, 1, 2, 3, 4, 6, 8}) continue;
            run_op(4'b0000, 8'hFF, 8'h01);
            run_op(4'(k), 8'hA5, 8'h5A);
            chk("R5", "zero set", int'(zero_flag), 1);
        end

        // R6: hold while compute_en low
        run_op(4'b0000, 8'd10, 8'd20);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            opnd_a = 8'($urandom); opnd_b = 8'($urandom); op_code = 4'($urandom);
            @(negedge clk);
            chk("R6", "hold result", int'(bus_data), 30);
            chk("R6", "hold zero", int'(zero_flag), 0);
            chk("R6", "hold carry", int'(carry_flag), 0);
        end

        // R7: output enable
        out_en = 1'b0;
        #1;
        chk("R7", "valid low", int'(bus_valid), 0);
        chk("R7", "data low", int'(bus_data), 0);
        @(negedge clk);
        out_en = 1'b1;
        #1;
        chk("R7", "valid high", int'(bus_valid), 1);
        chk("R7", "data back", int'(bus_data), 30);

        // R9: reset wins over compute_en
        run_op(4'b0000, 8'd255, 8'd2);
        @(negedge clk);
        rst = 1'b1; compute_en = 1'b1; op_code = 4'b0000; opnd_a = 8'd9; opnd_b = 8'd9;
        @(negedge clk);
        rst = 1'b0; compute_en = 1'b0;
        chk("R9", "reset priority result", int'(bus_data), 0);
        chk("R9", "reset priority carry", int'(carry_flag), 0);
        chk("R9", "reset priority zero", int'(zero_flag), 0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] op;
            op = 4'($urandom);
            if (k % 2 == 0) op = 4'($urandom_range(0, 4));
            run_op(op, 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule